// File: doc/BRIEF.md
# Multi-polynomial PRBS pattern generator

This block is a transmit-side test pattern source. On every clock it emits a parallel data word taken from a linear feedback shift register. Four one-hot enable inputs choose one of four feedback polynomials of order 7, 9, 23 and 31. A pattern-select input replaces the pseudo-random stream with a fixed square-wave word. The generator runs only while both the test enable and the generator clock enable are high. In every other state the output word is zero and the valid flag is low.

The register is seeded with all ones when the block is reset and whenever the effective polynomial changes. This keeps it out of the all-zero lock-up state. When a pattern is stopped and started again under the same polynomial, the stream continues from the point where it stopped.

Top module: `prbs_pattern_gen`

## Requirements
- R1: With PRBS-7 selected, each generated bit is the XOR of register stages 7 and 6 (x^7 + x^6 + 1). That bit shifts into stage 1, and every stage moves up by one.
- R2: With PRBS-9 selected, each generated bit is the XOR of stages 9 and 5 (x^9 + x^5 + 1), and it shifts in the same way.
- R3: With PRBS-23 selected, each generated bit is the XOR of stages 23 and 18 (x^23 + x^18 + 1), and it shifts in the same way.
- R4: With PRBS-31 selected, each generated bit is the XOR of stages 31 and 28 (x^31 + x^28 + 1), and it shifts in the same way.
- R5: For a DATA_W-bit word, the register advances DATA_W steps per clock. The first generated bit lands in bit 0 and the last one in bit DATA_W-1.
- R6: poly_en bit 0 selects PRBS-7, bit 1 selects PRBS-9, bit 2 selects PRBS-23 and bit 3 selects PRBS-31. When several bits are set, the highest-order polynomial wins.
- R7: When poly_en is all zeros, data_out is zero and data_vld is low.
- R8: Unless test_en and gen_clk_en are both 1, data_out is zero and data_vld is low, and the register holds its state.
- R9: The register is seeded with all ones at reset and in any cycle where the effective polynomial differs from the previous cycle's.
- R10: With sq_sel = 1 and the generator active, data_out has its lower DATA_W/2 bits at 1 and its upper DATA_W/2 bits at 0, with data_vld high. The register holds its state meanwhile.
- R11: Outputs are registered. Inputs sampled at one rising edge determine data_out and data_vld right after that edge.
- R12: Synchronous active-high reset drives data_out to zero and data_vld low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| poly_en | input | 4 | One-hot polynomial enables (bit 0 = order 7, bit 3 = order 31) |
| test_en | input | 1 | Pattern test enable |
| gen_clk_en | input | 1 | Generator clock enable |
| sq_sel | input | 1 | 1 = square wave, 0 = pseudo-random |
| data_out | output | DATA_W | Generated pattern word |
| data_vld | output | 1 | High when data_out carries a pattern |

## Verification
On every cycle the assertions check the gating and idle behaviour: both enables are needed, an empty polynomial selection idles the block, and an invalid word is zero. They also check that the square-wave word is exact, that a pseudo-random word is never all zeros, and that valid follows the enables one clock later. The exact bit sequence of each polynomial needs the bench's behavioural model. The same holds for the priority among several enables, reseeding on a polynomial switch, and the stream continuing after a pause or a square-wave interval. The bench compares its model against the design on every clock.

// File: rtl/prbs_gen_pkg.sv
package prbs_gen_pkg;

  localparam int LFSR_W = 31;

  typedef enum logic [2:0] {
    SEL_NONE = 3'd0,
    SEL_P7   = 3'd1,
    SEL_P9   = 3'd2,
    SEL_P23  = 3'd3,
    SEL_P31  = 3'd4
  } poly_sel_e;

  // Feedback bit for the chosen polynomial (stage n is bit n-1).
  function automatic logic fb_bit(input logic [LFSR_W-1:0] s, input poly_sel_e sel);
    logic b;
    case (sel)
      SEL_P7:  b = s[6]  ^ s[5];
      SEL_P9:  b = s[8]  ^ s[4];
      SEL_P23: b = s[22] ^ s[17];
      SEL_P31: b = s[30] ^ s[27];
      default: b = 1'b0;
    endcase
    return b;
  endfunction

  // Stages in use for the chosen polynomial.
  function automatic logic [LFSR_W-1:0] span_mask(input poly_sel_e sel);
    logic [LFSR_W-1:0] m;
    case (sel)
      SEL_P7:  m = LFSR_W'(32'h0000_007F);
      SEL_P9:  m = LFSR_W'(32'h0000_01FF);
      SEL_P23: m = LFSR_W'(32'h007F_FFFF);
      default: m = '1;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/prbs_poly_select.sv
module prbs_poly_select
  import prbs_gen_pkg::*;
(
  input  logic [3:0] poly_en,
  output poly_sel_e  sel_o
);
  // Highest-order enable wins.
  always_comb begin
    if (poly_en[3])      sel_o = SEL_P31;
    else if (poly_en[2]) sel_o = SEL_P23;
    else if (poly_en[1]) sel_o = SEL_P9;
    else if (poly_en[0]) sel_o = SEL_P7;
    else                 sel_o = SEL_NONE;
  end
endmodule

// File: rtl/prbs_lfsr_step.sv
module prbs_lfsr_step
  import prbs_gen_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [LFSR_W-1:0] state_i,
  input  poly_sel_e         sel_i,
  output logic [DATA_W-1:0] word_o,
  output logic [LFSR_W-1:0] state_o
);
  logic [LFSR_W-1:0] work;
  logic [LFSR_W-1:0] mask;
  logic              nb;

  // Unrolled DATA_W-step advance; first bit generated goes to bit 0.
  always_comb begin
    mask   = span_mask(sel_i);
    work   = state_i;
    word_o = '0;
    nb     = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      nb        = fb_bit(work, sel_i);
      word_o[i] = nb;
      work      = {work[LFSR_W-2:0], nb} & mask;
    end
    state_o = work;
  end
endmodule

// File: rtl/prbs_square_word.sv
module prbs_square_word #(
  parameter int DATA_W = 32
) (
  output logic [DATA_W-1:0] word_o
);
  localparam int HALF_W = DATA_W / 2;

  for (genvar g = 0; g < DATA_W; g++) begin : g_bit
    if (g < HALF_W) begin : g_hi
      assign word_o[g] = 1'b1;
    end else begin : g_lo
      assign word_o[g] = 1'b0;
    end
  end
endmodule

// File: rtl/prbs_pattern_gen.sv
module prbs_pattern_gen
  import prbs_gen_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        poly_en,
  input  logic              test_en,
  input  logic              gen_clk_en,
  input  logic              sq_sel,
  output logic [DATA_W-1:0] data_out,
  output logic              data_vld
);
  localparam logic [LFSR_W-1:0] SEED = '1;

  poly_sel_e         sel;
  poly_sel_e         sel_q;
  logic [LFSR_W-1:0] lfsr_q;
  logic [LFSR_W-1:0] base;
  logic [LFSR_W-1:0] next_state;
  logic [DATA_W-1:0] prbs_word;
  logic [DATA_W-1:0] sq_word;
  logic              active;

  prbs_poly_select u_sel (
    .poly_en (poly_en),
    .sel_o   (sel)
  );

  // Reseed whenever the effective polynomial differs from last cycle.
  assign base   = (sel != sel_q) ? SEED : lfsr_q;
  assign active = test_en & gen_clk_en & (sel != SEL_NONE);

  prbs_lfsr_step #(.DATA_W(DATA_W)) u_step (
    .state_i (base),
    .sel_i   (sel),
    .word_o  (prbs_word),
    .state_o (next_state)
  );

  prbs_square_word #(.DATA_W(DATA_W)) u_sq (
    .word_o (sq_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lfsr_q   <= SEED;
      sel_q    <= SEL_NONE;
      data_out <= '0;
      data_vld <= 1'b0;
    end else begin
      sel_q    <= sel;
      data_vld <= active;
      if (active && !sq_sel) lfsr_q <= next_state;
      else                   lfsr_q <= base;
      if (!active)     data_out <= '0;
      else if (sq_sel) data_out <= sq_word;
      else             data_out <= prbs_word;
    end
  end
endmodule

// File: rtl/prbs_pattern_gen_chk.sv
module prbs_pattern_gen_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [3:0]        poly_en,
  input logic              test_en,
  input logic              gen_clk_en,
  input logic              sq_sel,
  input logic [DATA_W-1:0] data_out,
  input logic              data_vld
);
  localparam int HALF_W = DATA_W / 2;
  localparam logic [DATA_W-1:0] SQ_WORD = {{(DATA_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};

  logic run;
  assign run = test_en && gen_clk_en && (poly_en != 4'b0000);

  a_r8_enables_gate: assert property (@(posedge clk) disable iff (rst)
    !(test_en && gen_clk_en) |=> !data_vld);

  a_r7_none_idle: assert property (@(posedge clk) disable iff (rst)
    (poly_en == 4'b0000) |=> (!data_vld && data_out == '0));

  a_r8_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !data_vld |-> (data_out == '0));

  a_r10_square_word: assert property (@(posedge clk) disable iff (rst)
    (run && sq_sel) |=> (data_vld && data_out == SQ_WORD));

  a_r11_valid_follows: assert property (@(posedge clk) disable iff (rst)
    run |=> data_vld);

  // A window of 31 or more bits of a maximal sequence always holds a one.
  if (DATA_W >= 31) begin : g_nz
    a_r9_word_nonzero: assert property (@(posedge clk) disable iff (rst)
      (run && !sq_sel) |=> (data_out != '0));
  end
endmodule

bind prbs_pattern_gen prbs_pattern_gen_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_prbs_pattern_gen.sv
`timescale 1ns/1ps
module tb_prbs_pattern_gen;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [3:0]        poly_en = 4'b0;
  logic              test_en = 1'b0;
  logic              gen_clk_en = 1'b0;
  logic              sq_sel = 1'b0;
  logic [DATA_W-1:0] data_out;
  logic              data_vld;

  always #2 clk = ~clk;

  prbs_pattern_gen #(.DATA_W(DATA_W)) dut (.*);

  int    errors = 0;
  int    checks = 0;
  bit    chk_on = 0;
  bit    done = 0;
  string cur_req = "R12";

  // Behavioural model
  longint            st = 0;
  int                prev_order = 0;
  logic [DATA_W-1:0] exp_out = '0;
  logic              exp_vld = 1'b0;

  function automatic int order_of(logic [3:0] en);
    if (en[3]) return 31;
    if (en[2]) return 23;
    if (en[1]) return 9;
    if (en[0]) return 7;
    return 0;
  endfunction

  function automatic int tap_of(int n);
    case (n)
      7: return 6;
      9: return 5;
      23: return 18;
      default: return 28;
    endcase
  endfunction

  always @(posedge clk) begin
    int n;
    chk_on <= 1'b1;
    if (rst) begin
      st = (64'd1 << 31) - 1;
      prev_order = 0;
      exp_out = '0;
      exp_vld = 1'b0;
    end else begin
      n = order_of(poly_en);
      if (n != prev_order) st = (64'd1 << 31) - 1;
      prev_order = n;
      if (test_en && gen_clk_en && n != 0) begin
        exp_vld = 1'b1;
        if (sq_sel) begin
          for (int i = 0; i < DATA_W; i++) exp_out[i] = (i < DATA_W/2);
        end else begin
          for (int i = 0; i < DATA_W; i++) begin
            longint b;
            b = ((st >> (n-1)) ^ (st >> (tap_of(n)-1))) & 1;
            exp_out[i] = b[0];
            st = ((st << 1) | b) & ((64'd1 << n) - 1);
          end
        end
      end else begin
        exp_vld = 1'b0;
        exp_out = '0;
      end
    end
  end

  always @(negedge clk) begin
    if (chk_on && !done) begin
      checks++;
      if (data_out !== exp_out || data_vld !== exp_vld) begin
        errors++;
        $display("FAIL %s: data_out=%h vld=%b expected data_out=%h vld=%b",
                 cur_req, data_out, data_vld, exp_out, exp_vld);
      end
    end
  end

  task automatic run_cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    run_cycles(3);
    rst = 1'b0;
    cur_req = "R12 reset state";
    run_cycles(2);
    test_en = 1; gen_clk_en = 1;
    cur_req = "R1 R5 R11 PRBS-7"; poly_en = 4'b0001; run_cycles(40);
    cur_req = "R2 R9 PRBS-9";     poly_en = 4'b0010; run_cycles(40);
    cur_req = "R3 R9 PRBS-23";    poly_en = 4'b0100; run_cycles(40);
    cur_req = "R4 R9 PRBS-31";    poly_en = 4'b1000; run_cycles(40);
    cur_req = "R6 priority all";  poly_en = 4'b1111; run_cycles(10);
    cur_req = "R6 priority 9/7";  poly_en = 4'b0011; run_cycles(10);
    cur_req = "R6 priority 23/9"; poly_en = 4'b0110; run_cycles(10);
    cur_req = "R8 test_en low";   test_en = 0; run_cycles(5);
    cur_req = "R8 resume";        test_en = 1; run_cycles(8);
    cur_req = "R8 clk_en low";    gen_clk_en = 0; run_cycles(5);
    cur_req = "R8 resume";        gen_clk_en = 1; run_cycles(8);
    cur_req = "R7 none selected"; poly_en = 4'b0000; run_cycles(6);
    cur_req = "R9 reseed P31";    poly_en = 4'b1000; run_cycles(6);
    cur_req = "R10 square";       sq_sel = 1; run_cycles(8);
    cur_req = "R10 resume prbs";  sq_sel = 0; run_cycles(8);
    cur_req = "R9 P7 again";      poly_en = 4'b0001; run_cycles(20);
    cur_req = "R12 mid reset";    rst = 1; run_cycles(3);
    rst = 0; cur_req = "R9 after reset"; run_cycles(20);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule